// File: doc/BRIEF.md
# Timed Manchester Reply Transmitter

This block sends a slave's reply on a serial line after the slave has received a frame. A rising edge on the receive strobe opens a short acceptance window. If the upstream state machine offers a reply word during that window, the block takes it. It then drives the word as an active-low Manchester II frame. The first falling edge of the frame comes at a fixed delay after the receive strobe, and that delay depends on the timing mode sampled with the strobe. If no word is offered, the window closes and the block becomes idle again, so input activity can be checked at once. After a reply has been sent, the block stays busy until the 60 µs response time, counted from the receive strobe, has run out.

All times are counted in quarter-microsecond units of `QTR_CLKS` clock cycles. The values below use the default `QTR_CLKS = 2`. An index *n* means the state seen after the *n*-th rising clock edge following the edge that first sees `rx_strb_i` high while the block is idle. That detecting edge is index 0.

The reply word enters through a valid/ready port. `tx_ready_o` is high only while the acceptance window is open. A transfer takes place on a clock edge where both `tx_valid_i` and `tx_ready_o` are high. The block never waits for the source: a word that is not offered while ready is high is not taken, and `tx_valid_i` is ignored at all other times. The source must therefore present its word inside the window. Holding the word until ready rises is not enough.

Top module: `mrt_reply_tx`

## Requirements
- R1: After reset, and whenever the block is idle, `line_o` is 1, and `tx_ready_o`, `busy_o` and `done_o` are 0.
- R2: A rising edge of `rx_strb_i` seen while idle raises `busy_o` and `tx_ready_o` from index 0. `tx_ready_o` stays high for 6.0 µs (24 units, indices 0 to 47) unless a transfer ends it earlier.
- R3: A transfer (`tx_valid_i` and `tx_ready_o` both high at an edge) captures `tx_data_i` and drops `tx_ready_o` at the next index. `tx_valid_i` while `tx_ready_o` is low has no effect on any output.
- R4: If the window closes without a transfer, `busy_o` falls at index 48 and `line_o` stays high.
- R5: The first falling edge of `line_o` appears at index 94 (11.75 µs) when `sync_i` was 1 at the strobe edge, and at index 98 (12.25 µs) when it was 0. Changes to `sync_i` after that edge have no effect on the reply.
- R6: The frame has seven 6 µs cells (48 clocks each), in this order: start bit 0, data bits `tx_data_i[0]` to `tx_data_i[3]`, a parity bit, and end bit 1. In each cell the line carries the bit's value in the first half and its inverse in the second half, so a 0 is low then high. The line returns high after the end bit.
- R7: `done_o` is high for exactly one cycle, at the index where the end cell finishes (first-edge index plus 336).
- R8: After a reply has been sent, `busy_o` stays high until index 480 (60 µs) and falls there.
- R9: A rising edge of `rx_strb_i` while `busy_o` is high is ignored and does not restart any timing.
- R10: The parity bit is the XOR of the four data bits (even parity over the data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_strb_i | input | 1 | Receive strobe; its rising edge starts a reply cycle |
| sync_i | input | 1 | Timing mode: 1 = synchronous lead, 0 = asynchronous lead |
| tx_valid_i | input | 1 | Reply word offered (the send strobe) |
| tx_ready_o | output | 1 | Acceptance window open |
| tx_data_i | input | DATA_W | Reply word, sent LSB first |
| line_o | output | 1 | Active-low Manchester serial output; idles high |
| busy_o | output | 1 | A reply cycle is in progress |
| done_o | output | 1 | One-cycle pulse when the end bit completes |

## Verification
The replies use words with mixed bits, all zeros and all ones. They are sent in both timing modes, with `sync_i` flipped right after the strobe. These runs separate correct capture of mode and data from capture of whatever values are present later. The word is offered at the first, a middle and the last window cycle, which exposes off-by-one window bounds. A run with no reply and a late offer tells the short idle return apart from the full response-time hold. It also shows that a late word never reaches the line. A second strobe in the middle of a reply shows whether busy periods restart.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_ARMED,
    ST_TX,
    ST_HOLD
  } mrt_state_t;

endpackage

// File: rtl/mrt_timebase.sv
module mrt_timebase #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] elapsed_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elapsed_o <= '0;
    else if (clear_i) elapsed_o <= '0;
    else if (run_i)   elapsed_o <= elapsed_o + 1'b1;
  end

endmodule

// File: rtl/mrt_ctrl.sv
module mrt_ctrl
  import mrt_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int DATA_W     = 4,
  parameter int WIN_CLKS   = 48,
  parameter int LEAD_SYNC  = 94,
  parameter int LEAD_ASYNC = 98,
  parameter int RESP_CLKS  = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_rise_i,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  elapsed_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              ser_done_i,
  output logic              tx_ready_o,
  output logic              busy_o,
  output logic              tb_clear_o,
  output logic              tb_run_o,
  output logic              ser_start_o,
  output logic [DATA_W-1:0] word_o
);

  localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN_CLKS - 1);
  localparam logic [CNT_W-1:0] RESP_LAST  = CNT_W'(RESP_CLKS - 1);
  localparam logic [CNT_W-1:0] SYNC_PRE   = CNT_W'(LEAD_SYNC - 1);
  localparam logic [CNT_W-1:0] ASYNC_PRE  = CNT_W'(LEAD_ASYNC - 1);

  mrt_state_t state_q, state_d;
  logic       mode_q;
  logic       accept;
  logic       resp_end;

  assign accept      = (state_q == ST_WIN) && tx_valid_i;
  assign resp_end    = (elapsed_i == RESP_LAST);
  assign tx_ready_o  = (state_q == ST_WIN);
  assign busy_o      = (state_q != ST_IDLE);
  assign tb_clear_o  = (state_q == ST_IDLE) && rx_rise_i;
  assign tb_run_o    = busy_o;
  assign ser_start_o = (state_q == ST_ARMED) &&
                       (elapsed_i == (mode_q ? SYNC_PRE : ASYNC_PRE));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rx_rise_i) state_d = ST_WIN;
      ST_WIN: begin
        if (accept)                      state_d = ST_ARMED;
        else if (elapsed_i == WIN_LAST)  state_d = ST_IDLE;
      end
      ST_ARMED: begin
        if (resp_end)         state_d = ST_IDLE;
        else if (ser_start_o) state_d = ST_TX;
      end
      ST_TX: begin
        if (resp_end)        state_d = ST_IDLE;
        else if (ser_done_i) state_d = ST_HOLD;
      end
      ST_HOLD:  if (resp_end) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      word_o  <= '0;
    end else begin
      state_q <= state_d;
      if (tb_clear_o) mode_q <= sync_i;
      if (accept)     word_o <= tx_data_i;
    end
  end

  // R3
  accept_closes_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R2
  window_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready_o) |-> $past(rx_rise_i));

  // R9
  no_restart_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rx_rise_i && !resp_end && !(state_q == ST_WIN && elapsed_i == WIN_LAST))
      |=> busy_o && (elapsed_i == $past(elapsed_i) + 1'b1));

  // R8
  done_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_done_i |-> busy_o);

endmodule

// File: rtl/mrt_serializer.sv
module mrt_serializer #(
  parameter int DATA_W    = 4,
  parameter int CELL_CLKS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              line_o,
  output logic              done_o
);

  localparam int FRAME_W  = DATA_W + 3;
  localparam int HALF     = CELL_CLKS / 2;
  localparam int PH_W     = $clog2(CELL_CLKS);
  localparam int IDX_W    = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] shreg_q;
  logic [PH_W-1:0]    phase_q;
  logic [IDX_W-1:0]   cell_q;
  logic               active_q;

  assign frame[0]         = 1'b0;
  assign frame[DATA_W+1]  = ^word_i;
  assign frame[DATA_W+2]  = 1'b1;

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    assign frame[i+1] = word_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      shreg_q  <= '0;
      phase_q  <= '0;
      cell_q   <= '0;
      line_o   <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        shreg_q  <= frame;
        phase_q  <= '0;
        cell_q   <= '0;
        line_o   <= frame[0];
      end else if (active_q) begin
        if (phase_q == PH_W'(CELL_CLKS - 1)) begin
          phase_q <= '0;
          if (cell_q == IDX_W'(FRAME_W - 1)) begin
            active_q <= 1'b0;
            line_o   <= 1'b1;
            done_o   <= 1'b1;
          end else begin
            cell_q  <= cell_q + 1'b1;
            shreg_q <= shreg_q >> 1;
            line_o  <= shreg_q[1];
          end
        end else begin
          phase_q <= phase_q + 1'b1;
          if (phase_q == PH_W'(HALF - 1)) line_o <= ~shreg_q[0];
        end
      end
    end
  end

  // R6
  mid_cell_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !start_i && phase_q == PH_W'(HALF - 1)) |=> (line_o != $past(line_o)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_i) |=> line_o);

endmodule

// File: rtl/mrt_reply_tx.sv
module mrt_reply_tx #(
  parameter int QTR_CLKS       = 2,
  parameter int DATA_W         = 4,
  parameter int WIN_QTR        = 24,
  parameter int SYNC_LEAD_QTR  = 47,
  parameter int ASYNC_LEAD_QTR = 49,
  parameter int CELL_QTR       = 24,
  parameter int RESP_QTR       = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strb_i,
  input  logic              sync_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              line_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int WIN_CLKS   = WIN_QTR * QTR_CLKS;
  localparam int LEAD_SYNC  = SYNC_LEAD_QTR * QTR_CLKS;
  localparam int LEAD_ASYNC = ASYNC_LEAD_QTR * QTR_CLKS;
  localparam int CELL_CLKS  = CELL_QTR * QTR_CLKS;
  localparam int RESP_CLKS  = RESP_QTR * QTR_CLKS;
  localparam int CNT_W      = $clog2(RESP_CLKS + 1);

  logic              rx_prev_q;
  logic              rx_rise;
  logic              tb_clear, tb_run, ser_start, ser_done;
  logic [CNT_W-1:0]  elapsed;
  logic [DATA_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev_q <= 1'b0;
    else        rx_prev_q <= rx_strb_i;
  end

  assign rx_rise = rx_strb_i && !rx_prev_q;

  mrt_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (tb_clear),
    .run_i     (tb_run),
    .elapsed_o (elapsed)
  );

  mrt_ctrl #(
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .WIN_CLKS   (WIN_CLKS),
    .LEAD_SYNC  (LEAD_SYNC),
    .LEAD_ASYNC (LEAD_ASYNC),
    .RESP_CLKS  (RESP_CLKS)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_rise_i   (rx_rise),
    .sync_i      (sync_i),
    .elapsed_i   (elapsed),
    .tx_valid_i  (tx_valid_i),
    .tx_data_i   (tx_data_i),
    .ser_done_i  (ser_done),
    .tx_ready_o  (tx_ready_o),
    .busy_o      (busy_o),
    .tb_clear_o  (tb_clear),
    .tb_run_o    (tb_run),
    .ser_start_o (ser_start),
    .word_o      (word)
  );

  mrt_serializer #(
    .DATA_W    (DATA_W),
    .CELL_CLKS (CELL_CLKS)
  ) i_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ser_start),
    .word_i  (word),
    .line_o  (line_o),
    .done_o  (ser_done)
  );

  assign done_o = ser_done;

  // R1
  low_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_o |-> busy_o);

  // R3
  ready_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |-> busy_o);

endmodule

// File: tb/test_mrt_reply_tx.sv
module test_mrt_reply_tx;

  localparam int W  = 48;
  localparam int FS = 94;
  localparam int FA = 98;
  localparam int B  = 48;
  localparam int NF = 7;
  localparam int R  = 480;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_strb_i = 1'b0;
  logic       sync_i = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic [3:0] tx_data_i = 4'h0;
  logic       tx_ready_o, line_o, busy_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  mrt_reply_tx i_mrt_reply_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_strb_i  (rx_strb_i),
    .sync_i     (sync_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .tx_data_i  (tx_data_i),
    .line_o     (line_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // behavioural reference model: 0 idle, 1 window, 2 replying
  int       m_state = 0;
  int       m_el = 0;
  bit       m_mode = 1'b0;
  bit [3:0] m_data = 4'h0;
  bit       m_prev = 1'b0;
  bit       m_line = 1'b1;
  bit       m_done = 1'b0;

  function automatic bit frame_bit(input bit [3:0] d, input int idx);
    if (idx == 0) return 1'b0;
    if (idx <= 4) return d[idx-1];
    if (idx == 5) return d[0] ^ d[1] ^ d[2] ^ d[3];
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_el = 0; m_mode = 1'b0; m_data = 4'h0;
      m_prev = 1'b0; m_line = 1'b1; m_done = 1'b0;
    end else begin
      bit rise;
      int lead;
      rise = rx_strb_i && !m_prev;
      m_prev = rx_strb_i;
      case (m_state)
        0: if (rise) begin m_state = 1; m_el = 0; m_mode = sync_i; end
        1: begin
          if (tx_valid_i) begin m_state = 2; m_data = tx_data_i; end
          else if (m_el == W - 1) m_state = 0;
          m_el++;
        end
        default: begin
          if (m_el == R - 1) m_state = 0;
          m_el++;
        end
      endcase
      lead = m_mode ? FS : FA;
      m_line = 1'b1;
      m_done = 1'b0;
      if (m_state == 2 && m_el >= lead && m_el < lead + NF * B) begin
        bit bv;
        bv = frame_bit(m_data, (m_el - lead) / B);
        m_line = (((m_el - lead) % B) < B / 2) ? bv : !bv;
      end
      if (m_state == 2 && m_el == lead + NF * B) m_done = 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check("R6 R10 line_o vs model", line_o, m_line);
      check("R2 tx_ready_o vs model", tx_ready_o, m_state == 1);
      check("R8 busy_o vs model", busy_o, m_state != 0);
      check("R7 done_o vs model", done_o, m_done);
    end
  end

  task automatic run_reply(input bit sync, input bit [3:0] data, input int acc_at,
                           input int extra_rx_at, input int late_at,
                           output int first_low, output int done_at,
                           output int busy_fall, output int ready_cnt,
                           output int par_lvl);
    int lead;
    lead = sync ? FS : FA;
    first_low = -1; done_at = -1; busy_fall = -1; ready_cnt = 0; par_lvl = -1;
    @(negedge clk);
    rx_strb_i = 1'b1;
    sync_i = sync;
    tx_data_i = ~data;
    @(posedge clk);
    @(negedge clk);
    rx_strb_i = 1'b0;
    sync_i = ~sync;
    for (int idx = 0; idx < R + 8; idx++) begin
      if (!line_o && first_low < 0) first_low = idx;
      if (done_o) done_at = idx;
      if (!busy_o && busy_fall < 0) busy_fall = idx;
      if (tx_ready_o) ready_cnt++;
      if (idx == lead + 5 * B) par_lvl = line_o;
      tx_valid_i = (idx == acc_at) || (idx == late_at);
      tx_data_i  = (idx == acc_at) ? data : ~data;
      rx_strb_i  = (idx == extra_rx_at);
      @(negedge clk);
    end
    tx_valid_i = 1'b0;
    rx_strb_i = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int fl, da, bf, rc, pl;
    repeat (3) @(negedge clk);
    check("R1 reset line_o", line_o, 1);
    check("R1 reset busy_o", busy_o, 0);
    check("R1 reset tx_ready_o", tx_ready_o, 0);
    check("R1 reset done_o", done_o, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (4) @(negedge clk);

    // sync reply, mid-window offer
    run_reply(1'b1, 4'b1011, 5, -1, -1, fl, da, bf, rc, pl);
    check("R5 sync first edge", fl, FS);
    check("R7 done index sync", da, FS + NF * B);
    check("R8 busy hold sync", bf, R);
    check("R3 ready ends after transfer", rc, 6);
    check("R10 parity 1011", pl, 1);

    // async reply, first-cycle offer, second strobe mid-reply
    run_reply(1'b0, 4'b0110, 0, 200, -1, fl, da, bf, rc, pl);
    check("R5 async first edge", fl, FA);
    check("R7 done index async", da, FA + NF * B);
    check("R9 strobe while busy ignored", bf, R);
    check("R10 parity 0110", pl, 0);

    // no reply, late offer
    run_reply(1'b1, 4'b0101, -1, -1, 50, fl, da, bf, rc, pl);
    check("R4 window expiry busy fall", bf, W);
    check("R2 window length", rc, W);
    check("R3 late offer leaves line high", fl, -1);
    check("R4 no done on miss", da, -1);

    // offer on last window cycle
    run_reply(1'b0, 4'b0000, W - 1, -1, -1, fl, da, bf, rc, pl);
    check("R3 last-cycle transfer", fl, FA);
    check("R6 all-zero frame done", da, FA + NF * B);
    check("R10 parity 0000", pl, 0);

    // all ones
    run_reply(1'b1, 4'b1111, 20, -1, -1, fl, da, bf, rc, pl);
    check("R6 all-one frame first edge", fl, FS);
    check("R10 parity 1111", pl, 0);
    check("R8 busy hold all-ones", bf, R);

    repeat (4) @(negedge clk);
    check("R1 idle line_o after run", line_o, 1);
    check("R1 idle busy_o after run", busy_o, 0);
    cmp_en = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule